// File: doc/BRIEF.md
# Uniform Random Table Address Source

This block supplies pseudo-random read addresses for a 168-entry, 8-bit lookup table, together with the table byte held at each address. An 8-bit maximal-length linear feedback shift register advances on every clock. Once every eight shifts, its whole state is taken as one candidate address. Taking the state only every eighth shift means that one candidate does not reuse the shifted bits of the one before it.

Candidates that fall outside the table are thrown away and are not folded back into range. A fold-back such as a modulo would make some addresses more likely than others, so dropping them keeps every legal address equally likely. Legal candidates wait in a small first-in first-out queue. The candidate rate is higher than the rate at which the consumer takes addresses, so the queue normally has addresses ready.

The consumer raises a request to take the oldest queued address. One cycle later the address and its table byte appear with a valid strobe. An empty flag tells the consumer when no address is waiting.

Top module: `rand_addr_gen`

## Requirements
- R1: After reset, `empty` is 1 and `rd_valid` is 0, and the shift register holds the seed 8'h01.
- R2: On every clock the shift register moves left by one bit. The new bit 0 is the XOR of the old bits 7, 3, 2 and 1, which is the polynomial x^8+x^4+x^3+x^2+1. The register therefore steps through all 255 nonzero states.
- R3: A candidate is the register value in each cycle whose phase counter reads 7. The counter is 0 in the first cycle after reset and counts 0 to 7 cyclically, so candidates are exactly eight shifts apart.
- R4: A candidate of 168 or more is discarded. Every delivered address lies in 0..167. With a request held high continuously from reset, each address from 1 to 167 is delivered exactly once within the first 2045 cycles, and address 0 is never delivered.
- R5: Accepted candidates are delivered in the order they were accepted, through an 8-entry queue.
- R6: When the queue holds 8 addresses, a legal candidate is dropped. The shift register keeps advancing. A pop in the same cycle does not make room for that candidate.
- R7: When `req` is 1 and `empty` is 0 at a clock edge, `rd_valid` is 1 in the following cycle. In that cycle `rd_addr` is the oldest queued address and `rd_data` equals (rd_addr*29+5) mod 256.
- R8: When `req` is 1 and `empty` is 1 at a clock edge, nothing is removed from the queue and `rd_valid` is 0 in the following cycle.
- R9: `empty` is 1 exactly when the queue holds no addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Take the oldest queued address |
| empty | output | 1 | No address is waiting |
| rd_valid | output | 1 | `rd_addr` and `rd_data` are valid this cycle |
| rd_addr | output | 8 | Delivered table address |
| rd_data | output | 8 | Table byte stored at `rd_addr` |

## Verification
A new candidate can be written into the queue in the same cycle that a request takes an address out of it. The same applies when the queue is full. When `req` is held high continuously, every accepted candidate is removed soon after it arrives, so writes and reads repeatedly land on the same edge. A long idle stretch fills the queue, and the drain that follows then meets candidates arriving while it is still full. Both cases are judged cycle by cycle. The bench compares the delivered address order and the `empty` flag against a queue model driven by the stated polynomial and phase rule.

// File: rtl/rand_addr_gen.sv
module rand_addr_gen #(
  parameter int          LW      = 8,
  parameter int          DW      = 8,
  parameter int          ENTRIES = 168,
  parameter int          DEPTH   = 8,
  parameter logic [LW-1:0] SEED  = 8'h01,
  parameter logic [LW-1:0] TAPS  = 8'b1000_1110,
  parameter int          MULT    = 29,
  parameter int          OFS     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  output logic                        empty,
  output logic                        rd_valid,
  output logic [$clog2(ENTRIES)-1:0]  rd_addr,
  output logic [DW-1:0]               rd_data
);
  localparam int AW  = $clog2(ENTRIES);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;
  localparam int PHW = $clog2(LW);

  logic [LW-1:0]  lfsr;
  logic [PHW-1:0] phase;
  logic [AW-1:0]  q [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  function automatic logic [DW-1:0] tbl(input logic [AW-1:0] a);
    return DW'(int'(a) * MULT + OFS);
  endfunction

  wire draw  = (phase == PHW'(LW - 1));
  wire legal = (lfsr < LW'(ENTRIES));
  wire full  = (cnt == CW'(DEPTH));
  wire push  = draw && legal && !full;
  wire pop   = req && !empty;

  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr  <= SEED;
      phase <= '0;
    end else begin
      lfsr  <= {lfsr[LW-2:0], ^(lfsr & TAPS)};
      phase <= phase + PHW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) q[wp] <= lfsr[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop;
      if (pop) begin
        rd_addr <= q[rp];
        rd_data <= tbl(q[rp]);
      end
    end
  end

  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0);
  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> rd_addr < AW'(ENTRIES));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R7
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) (req && !empty) |=> rd_valid);
  // R8
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) (req && empty) |=> !rd_valid);
  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (empty && !draw) |=> empty);
endmodule

// File: tb/rand_addr_gen_bench.sv
`timescale 1ns/1ps
module rand_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic empty, rd_valid;
  logic [7:0] rd_addr, rd_data;

  always #2 clk = ~clk;

  rand_addr_gen u_rand_addr_gen (
    .clk(clk), .rst_n(rst_n), .req(req), .empty(empty),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mlfsr;
  int mph, mhead, mcount;
  logic [7:0] mq [8];
  int seen [256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit r);
    bit ev, push;
    logic [7:0] ea;
    int tail;
    req = r;
    ev   = r && (mcount > 0);
    ea   = mq[mhead];
    push = (mph == 7) && (mlfsr < 168) && (mcount < 8);
    tail = (mhead + mcount) % 8;
    if (push) mq[tail] = mlfsr;
    if (ev) begin mhead = (mhead + 1) % 8; mcount--; end
    if (push) mcount++;
    mlfsr = {mlfsr[6:0], mlfsr[7] ^ mlfsr[3] ^ mlfsr[2] ^ mlfsr[1]};
    mph = (mph + 1) % 8;
    @(posedge clk);
    @(negedge clk);
    if (r && !ev) chk(rd_valid === 1'b0, "R8 valid", int'(rd_valid), 0);
    else          chk(rd_valid === ev, "R7 valid", int'(rd_valid), int'(ev));
    if (ev && rd_valid === 1'b1) begin
      chk(rd_addr === ea, "R5 order", int'(rd_addr), int'(ea));
      chk(rd_data === 8'((int'(rd_addr) * 29 + 5) % 256), "R7 data",
          int'(rd_data), (int'(rd_addr) * 29 + 5) % 256);
      seen[rd_addr]++;
    end
    chk(empty === (mcount == 0), "R9 empty", int'(empty), int'(mcount == 0));
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) seen[i] = 0;
    mlfsr = 8'h01; mph = 0; mhead = 0; mcount = 0;
    for (int i = 0; i < 8; i++) mq[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(empty === 1'b1, "R1 empty", int'(empty), 1);
    chk(rd_valid === 1'b0, "R1 valid", int'(rd_valid), 0);
    // R2 R3 R4: continuous request over a full period
    for (int i = 0; i < 2045; i++) cyc(1'b1);
    chk(seen[0] == 0, "R4 addr0", seen[0], 0);
    for (int a = 1; a < 168; a++) chk(seen[a] == 1, "R4 once", seen[a], 1);
    for (int a = 168; a < 256; a++) chk(seen[a] == 0, "R4 reject", seen[a], 0);
    // R6 fill while idle, then drain with candidates arriving
    for (int i = 0; i < 300; i++) cyc(1'b0);
    chk(mcount == 8, "R6 full", mcount, 8);
    for (int i = 0; i < 20; i++) cyc(1'b1);
    // R8 requests kept up across empty stretches
    for (int i = 0; i < 40; i++) cyc(1'b1);
    // mixed pattern
    for (int i = 0; i < 3000; i++) cyc((i % 3) == 0 || (i % 97) < 5);
    for (int i = 0; i < 200; i++) cyc((i % 29) == 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule